// File: doc/BRIEF.md
# Multiplexed Queue Flag Status Bus

This block publishes the almost-full and almost-empty condition of a large set of queues over two narrow byte-wide buses. The queues are grouped eight at a time into status words: word k carries queues 8k through 8k+7 (queues numbered from zero), with queue 8k on bit 0 and queue 8k+7 on bit 7. One bus carries almost-full flags and is clocked and addressed from the write side. The other carries almost-empty flags and is clocked and addressed from the read side. A monitor uses them to watch fill levels of queues that are not currently selected on either data port.

A single mode pin applies to both buses. In polled mode (`poll_mode` = 1) each bus steps to the next occupied status word on every rising edge of its own clock, wrapping to word 0 after the last word that holds a configured queue. In direct mode (`poll_mode` = 0) each bus shows the word named by its own select input, sampled on its own clock. Every bus is paired with a registered word index naming the group on show. Bits belonging to queue numbers at or above the configured count are forced to zero. The per-queue flags arrive ready-made. All pins are plain control and status pins: no data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `qflag_status_mux`

## Requirements
- R1: While a side's reset is low, that side's word index and flag byte read zero; both sides leave reset with word 0 and an all-zero byte.
- R2: After a clock edge the flag byte shows, on bit j, the flag of queue 8*idx+j sampled at that edge, where idx is the word index shown alongside it.
- R3: With `poll_mode` = 1, each edge moves the word index from i to i+1, or to 0 when i+1 is not below ceil(num_queues/8); only words holding a configured queue are ever shown.
- R4: The almost-full byte and index change only on `wclk` edges, the almost-empty byte and index only on `rclk` edges; stopping one clock freezes only its own side.
- R5: One `poll_mode` pin sets the scan mode of both buses at the same time.
- R6: With `poll_mode` = 0, each edge loads the word index from that side's select input; the two selects act independently.
- R7: In a word that is only partly occupied, bits whose queue number is at or above `num_queues` read zero whatever the flag inputs hold (22 queues: word 2 keeps only bits 0 to 5).
- R8: A direct select naming a word with no configured queue yields an all-zero byte while the index still reports the selected word.
- R9: With `num_queues` = 0 in polled mode, the index stays at 0 and the byte stays zero.
- R10: Outputs are registered: a flag change between two edges does not reach the byte until the next edge of that side's clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock, times the almost-full bus |
| wrst_n | input | 1 | Asynchronous active-low reset of the write side |
| rclk | input | 1 | Read-side clock, times the almost-empty bus |
| rrst_n | input | 1 | Asynchronous active-low reset of the read side |
| poll_mode | input | 1 | 1 = automatic polling, 0 = direct selection, both buses |
| num_queues | input | CNT_W | Number of configured queues, 0 to NUM_Q |
| af_flags | input | NUM_Q | Almost-full flag per queue, bit q for queue q |
| af_word_sel | input | IDX_W | Direct-mode word select for the almost-full bus |
| ae_flags | input | NUM_Q | Almost-empty flag per queue, bit q for queue q |
| ae_word_sel | input | IDX_W | Direct-mode word select for the almost-empty bus |
| af_bus | output | 8 | Almost-full status byte |
| af_word_idx | output | IDX_W | Index of the word on `af_bus` |
| ae_bus | output | 8 | Almost-empty status byte |
| ae_word_idx | output | IDX_W | Index of the word on `ae_bus` |

## Verification
A wrong word counter shows at the ports on the very next edge of its clock: the index breaks the +1/wrap pattern or lands on an unoccupied word, and the byte then carries flags of the wrong group. A faulty mask or group select surfaces as soon as a word is shown whose flags differ from their neighbours, so the bench drives distinct non-repeating patterns and partly filled counts such as 22 queues. Crossed clocking between sides appears only when one clock stops, so the bench halts the read clock while the write clock polls.

// File: rtl/qfs_pkg.sv
package qfs_pkg;

  localparam int unsigned WORD_BITS = 8;

  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_POLLED = 1'b1
  } scan_mode_e;

  // Number of status words that contain at least one configured queue.
  function automatic int unsigned words_in_use(input int unsigned nq);
    return (nq + WORD_BITS - 1) / WORD_BITS;
  endfunction

endpackage

// File: rtl/qfs_word_seq.sv
module qfs_word_seq
  import qfs_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned CNT_W     = 8
) (
  input  scan_mode_e       mode,
  input  logic [CNT_W-1:0] num_q,
  input  logic [IDX_W-1:0] cur_idx,
  input  logic [IDX_W-1:0] dir_idx,
  output logic [IDX_W-1:0] next_idx
);

  int unsigned used_w;
  int unsigned step_w;

  always_comb begin
    used_w = words_in_use(32'(num_q));
    if (used_w > NUM_WORDS) begin
      used_w = NUM_WORDS;
    end
    step_w = 32'(cur_idx) + 1;
    if (mode == MODE_DIRECT) begin
      next_idx = dir_idx;
    end else if ((used_w == 0) || (step_w >= used_w)) begin
      next_idx = '0;
    end else begin
      next_idx = IDX_W'(step_w);
    end
  end

endmodule

// File: rtl/qfs_word_mux.sv
module qfs_word_mux
  import qfs_pkg::*;
#(
  parameter int unsigned NUM_Q     = 128,
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned CNT_W     = 8
) (
  input  logic [NUM_Q-1:0]     flags,
  input  logic [CNT_W-1:0]     num_q,
  input  logic [IDX_W-1:0]     idx,
  output logic [WORD_BITS-1:0] word
);

  localparam int unsigned PAD_BITS = NUM_WORDS * WORD_BITS;

  logic [PAD_BITS-1:0]                       padded;
  logic [NUM_WORDS-1:0][WORD_BITS-1:0]       groups;
  logic [WORD_BITS-1:0]                      raw;
  logic [WORD_BITS-1:0]                      live;

  assign padded = PAD_BITS'(flags);
  assign groups = padded;

  always_comb begin
    if (32'(idx) < NUM_WORDS) begin
      raw = groups[idx];
    end else begin
      raw = '0;
    end
  end

  for (genvar j = 0; j < WORD_BITS; j++) begin : g_bit
    assign live[j] = ((32'(idx) * WORD_BITS + j) < 32'(num_q)) &&
                     ((32'(idx) * WORD_BITS + j) < NUM_Q);
    assign word[j] = raw[j] & live[j];
  end

endmodule

// File: rtl/qfs_side.sv
module qfs_side
  import qfs_pkg::*;
#(
  parameter int unsigned NUM_Q     = 128,
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned CNT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  scan_mode_e           mode,
  input  logic [CNT_W-1:0]     num_q,
  input  logic [NUM_Q-1:0]     flags,
  input  logic [IDX_W-1:0]     dir_idx,
  output logic [WORD_BITS-1:0] bus,
  output logic [IDX_W-1:0]     word_idx
);

  logic [IDX_W-1:0]     idx_q;
  logic [IDX_W-1:0]     idx_d;
  logic [WORD_BITS-1:0] byte_d;
  logic [WORD_BITS-1:0] byte_q;

  qfs_word_seq #(
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) u_seq (
    .mode     (mode),
    .num_q    (num_q),
    .cur_idx  (idx_q),
    .dir_idx  (dir_idx),
    .next_idx (idx_d)
  );

  // Byte is formed from the index being loaded, so index and byte agree.
  qfs_word_mux #(
    .NUM_Q     (NUM_Q),
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) u_mux (
    .flags (flags),
    .num_q (num_q),
    .idx   (idx_d),
    .word  (byte_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      byte_q <= '0;
    end else begin
      idx_q  <= idx_d;
      byte_q <= byte_d;
    end
  end

  assign bus      = byte_q;
  assign word_idx = idx_q;

endmodule

// File: rtl/qflag_status_mux.sv
module qflag_status_mux
  import qfs_pkg::*;
#(
  parameter  int unsigned NUM_Q     = 128,
  localparam int unsigned NUM_WORDS = (NUM_Q + WORD_BITS - 1) / WORD_BITS,
  localparam int unsigned IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned CNT_W     = $clog2(NUM_Q + 1)
) (
  input  logic                 wclk,
  input  logic                 wrst_n,
  input  logic                 rclk,
  input  logic                 rrst_n,
  input  logic                 poll_mode,
  input  logic [CNT_W-1:0]     num_queues,
  input  logic [NUM_Q-1:0]     af_flags,
  input  logic [IDX_W-1:0]     af_word_sel,
  input  logic [NUM_Q-1:0]     ae_flags,
  input  logic [IDX_W-1:0]     ae_word_sel,
  output logic [WORD_BITS-1:0] af_bus,
  output logic [IDX_W-1:0]     af_word_idx,
  output logic [WORD_BITS-1:0] ae_bus,
  output logic [IDX_W-1:0]     ae_word_idx
);

  scan_mode_e scan_mode;

  // One shared mode setting for both buses.
  assign scan_mode = poll_mode ? MODE_POLLED : MODE_DIRECT;

  qfs_side #(
    .NUM_Q     (NUM_Q),
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) u_full_side (
    .clk      (wclk),
    .rst_n    (wrst_n),
    .mode     (scan_mode),
    .num_q    (num_queues),
    .flags    (af_flags),
    .dir_idx  (af_word_sel),
    .bus      (af_bus),
    .word_idx (af_word_idx)
  );

  qfs_side #(
    .NUM_Q     (NUM_Q),
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) u_empty_side (
    .clk      (rclk),
    .rst_n    (rrst_n),
    .mode     (scan_mode),
    .num_q    (num_queues),
    .flags    (ae_flags),
    .dir_idx  (ae_word_sel),
    .bus      (ae_bus),
    .word_idx (ae_word_idx)
  );

endmodule

// File: rtl/qfs_checker.sv
module qfs_checker #(
  parameter int unsigned NUM_Q     = 128,
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned IDX_W     = 4,
  parameter int unsigned CNT_W     = 8
) (
  input logic             wclk,
  input logic             wrst_n,
  input logic             rclk,
  input logic             rrst_n,
  input logic             poll_mode,
  input logic [CNT_W-1:0] num_queues,
  input logic [NUM_Q-1:0] af_flags,
  input logic [IDX_W-1:0] af_word_sel,
  input logic [NUM_Q-1:0] ae_flags,
  input logic [IDX_W-1:0] ae_word_sel,
  input logic [7:0]       af_bus,
  input logic [IDX_W-1:0] af_word_idx,
  input logic [7:0]       ae_bus,
  input logic [IDX_W-1:0] ae_word_idx
);

  function automatic logic [IDX_W-1:0] wrap_of(input logic [IDX_W-1:0] i,
                                               input logic [CNT_W-1:0] nq);
    int unsigned occ;
    occ = (32'(nq) + 7) / 8;
    if (occ > NUM_WORDS) occ = NUM_WORDS;
    if (32'(i) + 1 >= occ) return '0;
    return IDX_W'(32'(i) + 1);
  endfunction

  function automatic logic [7:0] pick_of(input logic [NUM_Q-1:0] f,
                                         input logic [IDX_W-1:0] i,
                                         input logic [CNT_W-1:0] nq);
    logic [7:0] b;
    for (int j = 0; j < 8; j++) begin
      int unsigned q;
      q = 32'(i) * 8 + j;
      b[j] = (q < 32'(nq) && q < NUM_Q) ? 1'(f >> q) : 1'b0;
    end
    return b;
  endfunction

  logic [IDX_W-1:0] af_want_idx;
  logic [IDX_W-1:0] ae_want_idx;

  assign af_want_idx = poll_mode ? wrap_of(af_word_idx, num_queues) : af_word_sel;
  assign ae_want_idx = poll_mode ? wrap_of(ae_word_idx, num_queues) : ae_word_sel;

  // R1
  a_r1_af_reset_clear: assert property (@(posedge wclk)
    !wrst_n |=> (af_word_idx == '0 && af_bus == '0));
  a_r1_ae_reset_clear: assert property (@(posedge rclk)
    !rrst_n |=> (ae_word_idx == '0 && ae_bus == '0));

  // R3, R9
  a_r3_af_poll_step: assert property (@(posedge wclk) disable iff (!wrst_n)
    poll_mode |=> af_word_idx == $past(wrap_of(af_word_idx, num_queues)));
  a_r3_ae_poll_step: assert property (@(posedge rclk) disable iff (!rrst_n)
    poll_mode |=> ae_word_idx == $past(wrap_of(ae_word_idx, num_queues)));

  // R6
  a_r6_af_direct_load: assert property (@(posedge wclk) disable iff (!wrst_n)
    !poll_mode |=> af_word_idx == $past(af_word_sel));
  a_r6_ae_direct_load: assert property (@(posedge rclk) disable iff (!rrst_n)
    !poll_mode |=> ae_word_idx == $past(ae_word_sel));

  // R2, R7, R8
  a_r2_af_byte_content: assert property (@(posedge wclk) disable iff (!wrst_n)
    1'b1 |=> af_bus == $past(pick_of(af_flags, af_want_idx, num_queues)));
  a_r2_ae_byte_content: assert property (@(posedge rclk) disable iff (!rrst_n)
    1'b1 |=> ae_bus == $past(pick_of(ae_flags, ae_want_idx, num_queues)));

  // R7: no bit above the configured count is ever set
  a_r7_af_mask_tail: assert property (@(posedge wclk) disable iff (!wrst_n)
    $stable(num_queues) |-> (af_bus & ~pick_of({NUM_Q{1'b1}}, af_word_idx, num_queues)) == '0);
  a_r7_ae_mask_tail: assert property (@(posedge rclk) disable iff (!rrst_n)
    $stable(num_queues) |-> (ae_bus & ~pick_of({NUM_Q{1'b1}}, ae_word_idx, num_queues)) == '0);

endmodule

bind qflag_status_mux qfs_checker #(
  .NUM_Q     (NUM_Q),
  .NUM_WORDS (NUM_WORDS),
  .IDX_W     (IDX_W),
  .CNT_W     (CNT_W)
) u_qfs_checker (
  .wclk        (wclk),
  .wrst_n      (wrst_n),
  .rclk        (rclk),
  .rrst_n      (rrst_n),
  .poll_mode   (poll_mode),
  .num_queues  (num_queues),
  .af_flags    (af_flags),
  .af_word_sel (af_word_sel),
  .ae_flags    (ae_flags),
  .ae_word_sel (ae_word_sel),
  .af_bus      (af_bus),
  .af_word_idx (af_word_idx),
  .ae_bus      (ae_bus),
  .ae_word_idx (ae_word_idx)
);

// File: tb/test_qflag_status_mux.sv
`timescale 1ns/1ps
module test_qflag_status_mux;

  localparam int NQ = 128;
  localparam int IW = 4;
  localparam int CW = 8;

  logic          wclk = 1'b0;
  logic          rclk = 1'b0;
  logic          rclk_en = 1'b1;
  logic          wrst_n, rrst_n;
  logic          poll_mode;
  logic [CW-1:0] num_queues;
  logic [NQ-1:0] af_flags, ae_flags;
  logic [IW-1:0] af_word_sel, ae_word_sel;
  logic [7:0]    af_bus, ae_bus;
  logic [IW-1:0] af_word_idx, ae_word_idx;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 wclk = ~wclk;
  always #7 rclk = rclk_en ? ~rclk : 1'b0;

  qflag_status_mux #(.NUM_Q(NQ)) i_qflag_status_mux (
    .wclk(wclk), .wrst_n(wrst_n), .rclk(rclk), .rrst_n(rrst_n),
    .poll_mode(poll_mode), .num_queues(num_queues),
    .af_flags(af_flags), .af_word_sel(af_word_sel),
    .ae_flags(ae_flags), .ae_word_sel(ae_word_sel),
    .af_bus(af_bus), .af_word_idx(af_word_idx),
    .ae_bus(ae_bus), .ae_word_idx(ae_word_idx)
  );

  function automatic logic [7:0] exp_byte(input logic [NQ-1:0] f, input int k, input int nq);
    logic [7:0] b;
    for (int j = 0; j < 8; j++) begin
      int q;
      q = k * 8 + j;
      b[j] = (q < nq && q < NQ) ? 1'(f >> q) : 1'b0;
    end
    return b;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    wrst_n = 1'b0; rrst_n = 1'b0;
    poll_mode = 1'b1; num_queues = 8'd128;
    af_flags = {4{32'hA5C3_1E78}}; ae_flags = {4{32'h5A3C_E187}};
    af_word_sel = '0; ae_word_sel = '0;
    repeat (3) @(negedge wclk);
    check(af_word_idx == 0 && af_bus == 0, "R1 af in reset", {af_word_idx, af_bus}, 0);
    check(ae_word_idx == 0 && ae_bus == 0, "R1 ae in reset", {ae_word_idx, ae_bus}, 0);
    wrst_n = 1'b1; rrst_n = 1'b1;
  endtask

  task automatic t_direct();
    poll_mode = 1'b0; num_queues = 8'd128;
    for (int k = 0; k < NQ / 32; k++) begin
      af_flags[k*32 +: 32] = 32'h1357_9BDF ^ (32'h0F1E_2D3C * (k + 1));
      ae_flags[k*32 +: 32] = 32'hECA8_6420 ^ (32'h7B6A_5948 * (k + 1));
    end
    af_word_sel = 4'd5; ae_word_sel = 4'd11;
    @(negedge wclk); @(negedge wclk);
    check(af_word_idx == 5, "R6 af direct idx", af_word_idx, 5);
    check(af_bus == exp_byte(af_flags, 5, 128), "R2 af word 5", af_bus, exp_byte(af_flags, 5, 128));
    @(negedge rclk); @(negedge rclk);
    check(ae_word_idx == 11, "R6 R5 ae direct idx", ae_word_idx, 11);
    check(ae_bus == exp_byte(ae_flags, 11, 128), "R2 ae word 11", ae_bus, exp_byte(ae_flags, 11, 128));
    af_word_sel = 4'd15; ae_word_sel = 4'd0;
    @(negedge wclk); @(negedge wclk); @(negedge rclk); @(negedge rclk);
    check(af_word_idx == 15 && af_bus == exp_byte(af_flags, 15, 128), "R6 af word 15", af_bus, exp_byte(af_flags, 15, 128));
    check(ae_word_idx == 0 && ae_bus == exp_byte(ae_flags, 0, 128), "R6 ae word 0", ae_bus, exp_byte(ae_flags, 0, 128));
  endtask

  task automatic t_poll_partial();
    int prev;
    af_flags = '1; ae_flags = {NQ/2{2'b10}};
    num_queues = 8'd22; poll_mode = 1'b1;
    @(negedge wclk); @(negedge wclk);
    prev = int'(af_word_idx);
    check(prev < 3, "R3 af polled idx in use", prev, 2);
    for (int n = 0; n < 7; n++) begin
      @(negedge wclk);
      check(int'(af_word_idx) == (prev + 1) % 3, "R3 R5 af poll step", af_word_idx, (prev + 1) % 3);
      check(af_bus == exp_byte(af_flags, int'(af_word_idx), 22), "R7 R2 af polled byte", af_bus, exp_byte(af_flags, int'(af_word_idx), 22));
      if (af_word_idx == 2) check(af_bus == 8'h3F, "R7 af last word 22q", af_bus, 8'h3F);
      prev = int'(af_word_idx);
    end
    @(negedge rclk);
    prev = int'(ae_word_idx);
    for (int n = 0; n < 5; n++) begin
      @(negedge rclk);
      check(int'(ae_word_idx) == (prev + 1) % 3, "R3 R5 ae poll step", ae_word_idx, (prev + 1) % 3);
      check(ae_bus == exp_byte(ae_flags, int'(ae_word_idx), 22), "R7 ae polled byte", ae_bus, exp_byte(ae_flags, int'(ae_word_idx), 22));
      prev = int'(ae_word_idx);
    end
  endtask

  task automatic t_beyond();
    af_flags = '1; ae_flags = '1;
    num_queues = 8'd22; poll_mode = 1'b0;
    af_word_sel = 4'd9; ae_word_sel = 4'd15;
    @(negedge wclk); @(negedge wclk); @(negedge rclk); @(negedge rclk);
    check(af_word_idx == 9 && af_bus == 8'h00, "R8 af beyond configured", {af_word_idx, af_bus}, 12'h900);
    check(ae_word_idx == 15 && ae_bus == 8'h00, "R8 ae beyond configured", {ae_word_idx, ae_bus}, 12'hF00);
    af_word_sel = 4'd2;
    @(negedge wclk); @(negedge wclk);
    check(af_bus == 8'h3F, "R7 af direct partial word", af_bus, 8'h3F);
  endtask

  task automatic t_zero_queues();
    af_flags = '1; num_queues = 8'd0; poll_mode = 1'b1;
    for (int n = 0; n < 4; n++) begin
      @(negedge wclk);
      check(af_word_idx == 0 && af_bus == 0, "R9 no queues polled", {af_word_idx, af_bus}, 0);
    end
  endtask

  task automatic t_registered();
    poll_mode = 1'b0; num_queues = 8'd128; af_word_sel = 4'd4;
    af_flags = '0; af_flags[39:32] = 8'hC6;
    @(negedge wclk); @(negedge wclk);
    check(af_bus == 8'hC6, "R10 af settled", af_bus, 8'hC6);
    af_flags[39:32] = 8'h39;
    #2;
    check(af_bus == 8'hC6, "R10 af held until edge", af_bus, 8'hC6);
    @(negedge wclk);
    check(af_bus == 8'h39, "R10 af after edge", af_bus, 8'h39);
  endtask

  task automatic t_clock_isolation();
    logic [IW-1:0] ae_hold;
    logic [7:0]    ae_byte_hold;
    logic [IW-1:0] af_start;
    num_queues = 8'd128; poll_mode = 1'b1;
    @(negedge rclk);
    rclk_en = 1'b0;
    #20;
    ae_hold = ae_word_idx; ae_byte_hold = ae_bus;
    ae_flags = ~ae_flags;
    @(negedge wclk);
    af_start = af_word_idx;
    repeat (5) @(negedge wclk);
    check(ae_word_idx == ae_hold && ae_bus == ae_byte_hold, "R4 ae frozen without rclk", ae_word_idx, ae_hold);
    check(af_word_idx == IW'(af_start + 5), "R4 af advanced on wclk", af_word_idx, IW'(af_start + 5));
    rclk_en = 1'b1;
    @(negedge rclk); @(negedge rclk);
    check(ae_word_idx != ae_hold, "R4 ae resumes with rclk", ae_word_idx, IW'(ae_hold + 1));
  endtask

  initial begin
    repeat (20000) @(posedge wclk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 20000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_direct();
    t_poll_partial();
    t_beyond();
    t_zero_queues();
    t_registered();
    t_clock_isolation();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule